// File: doc/BRIEF.md
# Delay-Line Sampling Phase Tuner

This block calibrates the receive sampling delay of a card interface. When started, it reads the delay-setting register once and keeps the bits above the phase field. It then steps the phase field through every setting, from zero upward. At each setting it writes the register and asks an external probe engine for a pass or fail verdict.

While it sweeps, the block tracks contiguous runs of passing settings and remembers the midpoint of the longest run seen so far. If a usable midpoint exists at the end of the sweep, the block writes that setting back and reports it. If not, it repeats the whole sweep, up to a fixed number of attempts, and then reports failure.

The probe protocol, the data comparison and the delay line itself sit outside the block. A system uses the tuner by pulsing `start` and waiting for the `done` pulse. It then reads `error` and `phase_sel`.

Top module: `phase_tuner`

## Requirements
- R1: After `start` in idle, the block pulses `reg_rd_req` for one cycle, exactly once per tuning run. It keeps the returned word with the low PHASE_W bits cleared as the base for every write of that run.
- R2: During each sweep, the block writes base | phase for phase = 0, 1, …, 2^PHASE_W−1 in ascending order. Each write is followed by one single-cycle `probe_req`. The block waits for `probe_done` and samples `probe_pass` in that cycle before it writes the next phase.
- R3: When a failing phase closes a run that is strictly longer than the best run so far, the candidate becomes floor((run_start+run_end)/2). Of two equal-length runs, the earlier one is kept.
- R4: A run that is still open when the last phase (2^PHASE_W−1) passes is judged in the same way, with its end at that last phase.
- R5: A sweep succeeds when at least one phase passed and the candidate is nonzero. In the same cycle as the one-cycle `done` pulse, the block then writes base | candidate, drives `phase_sel` to the candidate and drives `error` low.
- R6: A failed sweep is repeated, for at most MAX_TRIES (default 3) sweeps per run. Every sweep starts with cleared run, best-length, pass-count and candidate state, so nothing carries over between sweeps.
- R7: When the last allowed sweep fails, `done` pulses with `error` high and `phase_sel` at 0, and no final write is issued.
- R8: `done` is high for exactly one cycle per run. `error` and `phase_sel` hold their values until the next run completes.
- R9: A `start` received while a run is in progress is ignored. It causes no extra read and no extra sweep, and it does not change the result.
- R10: A synchronous active-high `rst` returns the block to idle with all strobes low and no write pending. No writes or probes follow it until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a tuning run (ignored when busy) |
| probe_req | output | 1 | One-cycle request for a probe at the current phase |
| probe_done | input | 1 | Probe verdict valid |
| probe_pass | input | 1 | Probe verdict: 1 = pass |
| reg_rd_req | output | 1 | One-cycle read request for the delay-setting register |
| reg_rd_valid | input | 1 | Read data valid |
| reg_rd_data | input | REG_W | Read data |
| reg_wr_en | output | 1 | Delay-setting register write strobe |
| reg_wr_data | output | REG_W | Write data: preserved upper bits and phase field |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last run failed (held) |
| phase_sel | output | PHASE_W | Selected phase of the last run (held) |

## Verification
Corrupted run tracking shows up at the ports only at the end of a sweep. In the cycle of the `done` pulse, the final write's phase field and `phase_sel` differ from the midpoint that the pass pattern dictates. A tracker that does not clear between sweeps turns a result that should succeed on a later sweep into a wrong phase or an error. A bad phase counter or a lost base shows up sooner, on the very next register write, as a skipped phase or changed upper bits. Sequencing faults show up within a cycle or two, as a repeated strobe or a missing final write.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_INIT,
    ST_SET,
    ST_PROBE,
    ST_WAIT,
    ST_DECIDE
  } tuner_state_e;
endpackage

// File: rtl/tuner_run_tracker.sv
module tuner_run_tracker #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          pass,
  input  logic          last,
  input  logic [PW-1:0] idx,
  output logic          any_pass,
  output logic [PW-1:0] cand
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] pass_cnt_q;
  logic [CW-1:0] run_len_q;
  logic [CW-1:0] best_len_q;
  logic [PW-1:0] run_start_q;
  logic [PW-1:0] run_end_q;
  logic [PW-1:0] cand_q;

  logic [PW-1:0] start_eff;
  logic [CW-1:0] sum_open;
  logic [CW-1:0] sum_closed;
  logic [CW-1:0] len_open;

  always_comb begin
    start_eff  = (run_len_q == '0) ? idx : run_start_q;
    sum_open   = {1'b0, start_eff} + {1'b0, idx};
    sum_closed = {1'b0, run_start_q} + {1'b0, run_end_q};
    len_open   = run_len_q + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pass_cnt_q  <= '0;
      run_len_q   <= '0;
      best_len_q  <= '0;
      run_start_q <= '0;
      run_end_q   <= '0;
      cand_q      <= '0;
    end else if (step) begin
      if (pass) begin
        pass_cnt_q <= pass_cnt_q + CNT_ONE;
        if (run_len_q == '0) run_start_q <= idx;
        run_end_q <= idx;
        run_len_q <= len_open;
        if (last && (len_open > best_len_q)) cand_q <= sum_open[CW-1:1];
      end else begin
        if (run_len_q > best_len_q) begin
          cand_q     <= sum_closed[CW-1:1];
          best_len_q <= run_len_q;
        end
        run_len_q <= '0;
      end
    end
  end

  assign any_pass = (pass_cnt_q != '0);
  assign cand     = cand_q;
endmodule

// File: rtl/tuner_seq.sv
module tuner_seq
  import tuner_pkg::*;
#(
  parameter int PW        = 14,
  parameter int MAX_TRIES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd_valid,
  input  logic          probe_done,
  input  logic          any_pass,
  input  logic [PW-1:0] cand,
  output logic          trk_clr,
  output logic          trk_step,
  output logic          trk_last,
  output logic [PW-1:0] idx,
  output logic          base_load,
  output logic          wr_req,
  output logic [PW-1:0] wr_phase,
  output logic          rd_req,
  output logic          probe_req,
  output logic          done,
  output logic          error,
  output logic [PW-1:0] phase_sel
);
  localparam int TW = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);
  localparam logic [TW-1:0] TRY_ONE  = TW'(1);
  localparam logic [PW-1:0] IDX_ONE  = PW'(1);

  tuner_state_e  state_q;
  logic [PW-1:0] idx_q;
  logic [TW-1:0] tries_q;
  logic          good;
  logic          final_try;

  always_comb begin
    good      = any_pass && (cand != '0);
    final_try = (tries_q == LAST_TRY);
    trk_clr   = (state_q == ST_INIT);
    trk_step  = (state_q == ST_WAIT) && probe_done;
    trk_last  = &idx_q;
    base_load = (state_q == ST_RD_WAIT) && rd_valid;
    wr_req    = (state_q == ST_SET) || ((state_q == ST_DECIDE) && good);
    wr_phase  = (state_q == ST_DECIDE) ? cand : idx_q;
    idx       = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      tries_q   <= '0;
      rd_req    <= 1'b0;
      probe_req <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      phase_sel <= '0;
    end else begin
      rd_req    <= 1'b0;
      probe_req <= 1'b0;
      done      <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            rd_req  <= 1'b1;
            tries_q <= '0;
            state_q <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (rd_valid) state_q <= ST_INIT;
        end
        ST_INIT: begin
          idx_q   <= '0;
          state_q <= ST_SET;
        end
        ST_SET: begin
          state_q <= ST_PROBE;
        end
        ST_PROBE: begin
          probe_req <= 1'b1;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (probe_done) begin
            if (trk_last) begin
              state_q <= ST_DECIDE;
            end else begin
              idx_q   <= idx_q + IDX_ONE;
              state_q <= ST_SET;
            end
          end
        end
        ST_DECIDE: begin
          if (good) begin
            done      <= 1'b1;
            error     <= 1'b0;
            phase_sel <= cand;
            state_q   <= ST_IDLE;
          end else if (final_try) begin
            done      <= 1'b1;
            error     <= 1'b1;
            phase_sel <= '0;
            state_q   <= ST_IDLE;
          end else begin
            tries_q <= tries_q + TRY_ONE;
            state_q <= ST_INIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tuner_reg_path.sv
module tuner_reg_path #(
  parameter int RW = 16,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_load,
  input  logic [RW-1:0] rd_data,
  input  logic          wr_req,
  input  logic [PW-1:0] wr_phase,
  output logic          reg_wr_en,
  output logic [RW-1:0] reg_wr_data
);
  localparam logic [RW-1:0] FIELD_MASK = {{(RW-PW){1'b0}}, {PW{1'b1}}};

  logic [RW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q      <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
    end else begin
      if (base_load) base_q <= rd_data & ~FIELD_MASK;
      reg_wr_en <= wr_req;
      if (wr_req) reg_wr_data <= base_q | {{(RW-PW){1'b0}}, wr_phase};
    end
  end
endmodule

// File: rtl/phase_tuner.sv
module phase_tuner #(
  parameter int PHASE_W   = 14,
  parameter int REG_W     = 16,
  parameter int MAX_TRIES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               probe_req,
  input  logic               probe_done,
  input  logic               probe_pass,
  output logic               reg_rd_req,
  input  logic               reg_rd_valid,
  input  logic [REG_W-1:0]   reg_rd_data,
  output logic               reg_wr_en,
  output logic [REG_W-1:0]   reg_wr_data,
  output logic               done,
  output logic               error,
  output logic [PHASE_W-1:0] phase_sel
);
  logic               trk_clr;
  logic               trk_step;
  logic               trk_last;
  logic [PHASE_W-1:0] trk_idx;
  logic               any_pass;
  logic [PHASE_W-1:0] cand;
  logic               base_load;
  logic               wr_req;
  logic [PHASE_W-1:0] wr_phase;

  tuner_seq #(.PW(PHASE_W), .MAX_TRIES(MAX_TRIES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_valid  (reg_rd_valid),
    .probe_done(probe_done),
    .any_pass  (any_pass),
    .cand      (cand),
    .trk_clr   (trk_clr),
    .trk_step  (trk_step),
    .trk_last  (trk_last),
    .idx       (trk_idx),
    .base_load (base_load),
    .wr_req    (wr_req),
    .wr_phase  (wr_phase),
    .rd_req    (reg_rd_req),
    .probe_req (probe_req),
    .done      (done),
    .error     (error),
    .phase_sel (phase_sel)
  );

  tuner_run_tracker #(.PW(PHASE_W)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .clr     (trk_clr),
    .step    (trk_step),
    .pass    (probe_pass),
    .last    (trk_last),
    .idx     (trk_idx),
    .any_pass(any_pass),
    .cand    (cand)
  );

  tuner_reg_path #(.RW(REG_W), .PW(PHASE_W)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .base_load  (base_load),
    .rd_data    (reg_rd_data),
    .wr_req     (wr_req),
    .wr_phase   (wr_phase),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_data(reg_wr_data)
  );
endmodule

// File: rtl/phase_tuner_chk.sv
module phase_tuner_chk #(
  parameter int PW = 14,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          probe_req,
  input logic          reg_rd_req,
  input logic          reg_wr_en,
  input logic [RW-1:0] reg_wr_data,
  input logic          done,
  input logic          error,
  input logic [PW-1:0] phase_sel
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  probe_single_chk: assert property (@(posedge clk) disable iff (rst)
    probe_req |=> !probe_req);

  // R2
  probe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(probe_req && reg_wr_en));

  // R1
  read_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |=> !reg_rd_req);

  // R5
  success_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (reg_wr_en && (phase_sel != '0) &&
                          (reg_wr_data[PW-1:0] == phase_sel)));

  // R7
  fail_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> (!reg_wr_en && (phase_sel == '0)));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(phase_sel)));
endmodule

bind phase_tuner phase_tuner_chk #(.PW(PHASE_W), .RW(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .probe_req  (probe_req),
  .reg_rd_req (reg_rd_req),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_data(reg_wr_data),
  .done       (done),
  .error      (error),
  .phase_sel  (phase_sel)
);

// File: tb/tb_phase_tuner.sv
`timescale 1ns/1ps
module tb_phase_tuner;
  localparam int PW  = 5;
  localparam int RW  = 16;
  localparam int NPH = 1 << PW;

  // vector: pat0[119:88] pat1[87:56] pat2[55:24] init[23:8] err[7] phase[6:2] sweeps[1:0]
  localparam logic [119:0] VEC [10] = '{
    {32'h00000FF0, 32'h00000FF0, 32'h00000FF0, 16'hA5A5, 1'b0, 5'd7,  2'd1},
    {32'h000FFC1C, 32'h000FFC1C, 32'h000FFC1C, 16'h0000, 1'b0, 5'd14, 2'd1},
    {32'h00F0001E, 32'h00F0001E, 32'h00F0001E, 16'hFFFF, 1'b0, 5'd2,  2'd1},
    {32'hFF000007, 32'hFF000007, 32'hFF000007, 16'h1234, 1'b0, 5'd27, 2'd1},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001, 1'b0, 5'd15, 2'd1},
    {32'h00000001, 32'h00000001, 32'h00000001, 16'h7E00, 1'b1, 5'd0,  2'd3},
    {32'h00000000, 32'h00000000, 32'h0000F000, 16'h3C3C, 1'b0, 5'd13, 2'd3},
    {32'h00000001, 32'h00000004, 32'h00000000, 16'hC0DE, 1'b0, 5'd2,  2'd2},
    {32'h00000000, 32'h00000000, 32'h00000000, 16'h5555, 1'b1, 5'd0,  2'd3},
    {32'h80000000, 32'h80000000, 32'h80000000, 16'h0F0F, 1'b0, 5'd31, 2'd1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          probe_req;
  logic          probe_done = 1'b0;
  logic          probe_pass = 1'b0;
  logic          reg_rd_req;
  logic          reg_rd_valid = 1'b0;
  logic [RW-1:0] reg_rd_data = '0;
  logic          reg_wr_en;
  logic [RW-1:0] reg_wr_data;
  logic          done;
  logic          error;
  logic [PW-1:0] phase_sel;

  phase_tuner #(.PHASE_W(PW), .REG_W(RW), .MAX_TRIES(3)) dut (
    .clk, .rst, .start, .probe_req, .probe_done, .probe_pass,
    .reg_rd_req, .reg_rd_valid, .reg_rd_data, .reg_wr_en, .reg_wr_data,
    .done, .error, .phase_sel
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0]   pat [3];
  logic [RW-1:0] init_val = '0;
  int sweeps, rd_reqs, wr_cnt, seq_bad, probes, cur_ph;
  logic          done_seen = 1'b0;
  logic          cap_err, cap_wr;
  logic [PW-1:0] cap_sel;
  logic [RW-1:0] cap_wdata;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // probe engine, register and delay-line model
  initial begin
    forever begin
      @(negedge clk);
      probe_done   = 1'b0;
      reg_rd_valid = 1'b0;
      if (reg_rd_req === 1'b1) begin
        rd_reqs++;
        reg_rd_valid = 1'b1;
        reg_rd_data  = init_val;
      end
      if (reg_wr_en === 1'b1 && done !== 1'b1) begin
        int ph;
        ph = int'(reg_wr_data[PW-1:0]);
        wr_cnt++;
        if (reg_wr_data[RW-1:PW] !== init_val[RW-1:PW]) seq_bad++;
        if (ph == 0) sweeps++;
        else if (ph != cur_ph + 1) seq_bad++;
        cur_ph = ph;
      end
      if (probe_req === 1'b1) begin
        int s;
        s = (sweeps < 1) ? 0 : ((sweeps > 3) ? 2 : sweeps - 1);
        probes++;
        probe_done = 1'b1;
        probe_pass = pat[s][cur_ph];
      end
      if (done === 1'b1) begin
        done_seen = 1'b1;
        cap_err   = error;
        cap_sel   = phase_sel;
        cap_wr    = reg_wr_en;
        cap_wdata = reg_wr_data;
      end
    end
  end

  task automatic load_case(input logic [119:0] v);
    pat[0] = v[119:88];
    pat[1] = v[87:56];
    pat[2] = v[55:24];
    init_val = v[23:8];
    sweeps = 0; rd_reqs = 0; wr_cnt = 0; seq_bad = 0; probes = 0; cur_ph = 0;
    done_seen = 1'b0;
  endtask

  task automatic run_case(input logic [119:0] v, input int poke);
    load_case(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (done_seen);
    @(negedge clk);
    chk("R8", "done low after pulse", done, 0);
  endtask

  task automatic check_vec(input logic [119:0] v);
    logic          e;
    logic [PW-1:0] p;
    logic [RW-1:0] expw;
    e = v[7];
    p = v[6:2];
    expw = (v[23:8] & ~RW'(NPH - 1)) | RW'(p);
    chk("R5/R7", "error flag", cap_err, e);
    chk("R3/R4/R5", "phase_sel", cap_sel, e ? 0 : p);
    chk("R5/R7", "final write strobe", cap_wr, !e);
    if (!e) chk("R5", "final write data", cap_wdata, expw);
    chk("R6", "sweep count", sweeps, v[1:0]);
    chk("R2", "write order and upper bits", seq_bad, 0);
    chk("R2", "probes per sweep", probes, sweeps * NPH);
    chk("R1", "read requests", rd_reqs, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w0, p0;
    pat[0] = '0; pat[1] = '0; pat[2] = '0;
    sweeps = 0; rd_reqs = 0; wr_cnt = 0; seq_bad = 0; probes = 0; cur_ph = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done in reset", done, 0);
    chk("R10", "error in reset", error, 0);
    chk("R10", "probe_req in reset", probe_req, 0);
    chk("R10", "wr_en in reset", reg_wr_en, 0);
    chk("R10", "rd_req in reset", reg_rd_req, 0);
    chk("R10", "phase_sel in reset", phase_sel, 0);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      run_case(VEC[i], 0);
      check_vec(VEC[i]);
    end

    // R9 start while busy
    run_case(VEC[1], 30);
    check_vec(VEC[1]);
    chk("R9", "sweeps after busy start", sweeps, 1);

    // R10 reset in the middle of a sweep
    load_case(VEC[0]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "probe_req after reset", probe_req, 0);
    chk("R10", "wr_en after reset", reg_wr_en, 0);
    chk("R10", "done after reset", done, 0);
    rst = 1'b0;
    w0 = wr_cnt;
    p0 = probes;
    repeat (30) @(negedge clk);
    chk("R10", "writes after reset", wr_cnt, w0);
    chk("R10", "probes after reset", probes, p0);

    run_case(VEC[0], 0);
    check_vec(VEC[0]);
    // R8 held results
    repeat (5) @(negedge clk);
    chk("R8", "phase_sel held", phase_sel, 7);
    chk("R8", "error held", error, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule